// File: doc/BRIEF.md
# Period Timer with Compare-Driven Clear

A free-running 16-bit up-counter that steps once per cycle in which its count-enable input is high, together with a 16-bit compare register, a compare-mode field and a sticky wrap flag. When the count passes from all ones back to zero the flag latches, and an interrupt request is raised while the flag is set and the interrupt enable is high. Software clears the flag with a one-cycle clear strobe.

When the compare-mode field holds the special-event code and the synchronous clock source is selected, a count equal to the compare value clears the counter on the next edge. The compare register therefore sets the counting period, and the block emits a one-cycle conversion-start pulse for an analog-to-digital converter when that converter is enabled. A compare-driven clear never sets the wrap flag, and a bus write to the counter wins over a clear in the same cycle.

Top module: `cmp_reset_timer`

## Requirements
- R1: After reset the count, the compare value, the wrap flag, the interrupt request and the conversion-start pulse are all zero.
- R2: In a cycle with no bus write and no compare clear, the count goes up by one when `tick_en` is high and holds when it is low; from 16'hFFFF it steps to 16'h0000.
- R3: A step from 16'hFFFF to 16'h0000 sets `ovf_flag` at that edge; `ovf_irq` equals `ovf_flag` AND `ovf_irq_en`.
- R4: When `cmp_mode` equals 4'b1011, `async_sel` is low and the count equals the compare value, the count reads zero after the next edge whether or not `tick_en` is high.
- R5: A compare-driven clear never sets `ovf_flag`, also when the compare value is 16'hFFFF.
- R6: A bus write (`cnt_wr_en` high) loads `cnt_wr_data` at the next edge, winning over a compare-driven clear and a step in the same cycle.
- R7: A compare match as in R4 with `adc_en` high makes `conv_start` high for exactly the one cycle after the match edge; with `adc_en` low no pulse appears.
- R8: With `cmp_mode` other than 4'b1011, or with `async_sel` high, a count equal to the compare value neither clears the counter nor pulses `conv_start`.
- R9: `ovf_flag` stays set until `ovf_clr` is high at an edge; when a wrap and a clear fall in the same cycle the flag ends set.
- R10: A compare write (`cmp_wr_en` high) makes `cmp_value` equal `cmp_wr_data` after the next edge; a match in that same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count step enable |
| async_sel | input | 1 | Asynchronous clock source selected; blocks the compare clear |
| cnt_wr_en | input | 1 | Bus write strobe for the count |
| cnt_wr_data | input | 16 | Value loaded by a count write |
| cmp_wr_en | input | 1 | Write strobe for the compare register |
| cmp_wr_data | input | 16 | Value loaded by a compare write |
| cmp_mode | input | 4 | Compare-mode field; 4'b1011 selects the special event |
| adc_en | input | 1 | Converter enable; gates the conversion-start pulse |
| ovf_irq_en | input | 1 | Wrap interrupt enable |
| ovf_clr | input | 1 | Clears the wrap flag |
| count | output | 16 | Current count |
| cmp_value | output | 16 | Current compare value |
| ovf_flag | output | 1 | Sticky wrap flag |
| ovf_irq | output | 1 | Wrap interrupt request |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
The counter is driven with gapped and continuous tick patterns and preloaded near all ones, which separates a plain step from a hold and from a wrap with its flag and interrupt gating. Compare runs repeat with the special code and the converter on, with the converter off, with a neighbouring mode code and with the asynchronous source, so a clear or pulse that ignores any one qualifier shows up. Collisions are staged on purpose: a write against a match, a clear against a wrap, a compare write against a match, and a compare value of all ones where a clear and a wrap coincide.

// File: rtl/cmp_reset_timer_pkg.sv
package cmp_reset_timer_pkg;

  localparam int unsigned MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_SPECIAL_EVT = 4'b1011;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_STEP  = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_LOAD  = 2'd3
  } cnt_cmd_e;

  // Priority of the counter update: bus load, then compare clear, then step.
  function automatic cnt_cmd_e pick_cmd(input logic wr, input logic hit,
                                        input logic tick);
    if (wr)        return CMD_LOAD;
    else if (hit)  return CMD_CLEAR;
    else if (tick) return CMD_STEP;
    else           return CMD_HOLD;
  endfunction

endpackage

// File: rtl/crt_compare.sv
module crt_compare
  import cmp_reset_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_wr_en,
  input  logic [CNT_W-1:0]  cmp_wr_data,
  input  logic [MODE_W-1:0] cmp_mode,
  input  logic              async_sel,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              hit
);

  function automatic logic special_match(input logic [MODE_W-1:0] mode,
                                         input logic asy,
                                         input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] ref_v);
    return (mode == MODE_SPECIAL_EVT) && !asy && (cnt == ref_v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         cmp_q <= '0;
    else if (cmp_wr_en) cmp_q <= cmp_wr_data;
  end

  assign hit = special_match(cmp_mode, async_sel, count, cmp_q);

  // R8: asynchronous source or other mode never yields a match
  p_no_hit_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (async_sel || cmp_mode != MODE_SPECIAL_EVT) |-> !hit);

  // R10: compare write lands at the next edge
  p_cmp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> cmp_q == $past(cmp_wr_data));

endmodule

// File: rtl/crt_counter.sv
module crt_counter
  import cmp_reset_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_cmd_e         cmd,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [CNT_W-1:0] next_count(input cnt_cmd_e c,
                                                  input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] ld);
    case (c)
      CMD_LOAD:  return ld;
      CMD_CLEAR: return '0;
      CMD_STEP:  return cur + 1'b1;
      default:   return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(cmd, count, wr_data);
  end

  assign wrap = (cmd == CMD_STEP) && (count == ALL_ONES);

  // R2: a step adds one, a hold keeps the value
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_STEP |=> count == $past(count) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_HOLD |=> $stable(count));

  // R3: a wrap lands on zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);

endmodule

// File: rtl/crt_flag.sv
module crt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  // R9: flag is sticky without a clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R9: set wins against clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R3: a flag can only rise on a wrap
  p_rise_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set));

endmodule

// File: rtl/cmp_reset_timer.sv
module cmp_reset_timer
  import cmp_reset_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              async_sel,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              cmp_wr_en,
  input  logic [CNT_W-1:0]  cmp_wr_data,
  input  logic [MODE_W-1:0] cmp_mode,
  input  logic              adc_en,
  input  logic              ovf_irq_en,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmp_value,
  output logic              ovf_flag,
  output logic              ovf_irq,
  output logic              conv_start
);

  // Named internal events
  logic     cmp_hit;
  logic     cnt_wrap;
  cnt_cmd_e cnt_cmd;
  logic     conv_q;

  crt_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .cmp_mode    (cmp_mode),
    .async_sel   (async_sel),
    .count       (count),
    .cmp_q       (cmp_value),
    .hit         (cmp_hit)
  );

  assign cnt_cmd = pick_cmd(cnt_wr_en, cmp_hit, tick_en);

  crt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cnt_cmd),
    .wr_data (cnt_wr_data),
    .count   (count),
    .wrap    (cnt_wrap)
  );

  crt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (cnt_wrap),
    .clr    (ovf_clr),
    .irq_en (ovf_irq_en),
    .flag   (ovf_flag),
    .irq    (ovf_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) conv_q <= 1'b0;
    else        conv_q <= cmp_hit & adc_en;
  end

  assign conv_start = conv_q;

  // R4: match without write clears the count
  p_match_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !cnt_wr_en) |=> count == '0);
  // R6: bus write wins
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> count == $past(cnt_wr_data));
  // R5: compare clear never produces a wrap
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> !cnt_wrap);
  // R7: pulse follows a gated match, and only that
  p_conv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && adc_en) |=> conv_start);
  p_conv_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_hit && adc_en) |=> !conv_start);

endmodule

// File: tb/cmp_reset_timer_bench.sv
module cmp_reset_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, async_sel = 1'b0, cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0, cmp_wr_data = '0;
  logic        cmp_wr_en = 1'b0, adc_en = 1'b0, ovf_irq_en = 1'b0, ovf_clr = 1'b0;
  logic [3:0]  cmp_mode = 4'h0;
  logic [15:0] count, cmp_value;
  logic        ovf_flag, ovf_irq, conv_start;

  always #2.5 clk = ~clk;

  cmp_reset_timer u_cmp_reset_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .async_sel(async_sel),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .cmp_mode(cmp_mode), .adc_en(adc_en), .ovf_irq_en(ovf_irq_en),
    .ovf_clr(ovf_clr), .count(count), .cmp_value(cmp_value),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .conv_start(conv_start)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // scoreboard: {count, cmp_value, flag, irq, conv}
  logic [34:0] exp_q[$];
  string       tag_q[$];

  // bench-side reference state
  logic [15:0] m_cnt = '0, m_cmp = '0;
  logic        m_flg = 1'b0, m_cv = 1'b0;

  // global qualifiers applied with each cycle
  logic [3:0] g_mode = 4'h0;
  logic       g_async = 1'b0, g_adc = 1'b0, g_ien = 1'b0;

  task automatic cyc(input logic tick, input logic wr, input logic [15:0] wd,
                     input logic cwr, input logic [15:0] cd, input logic clr,
                     input string tag);
    logic        period_end, rolled;
    logic [15:0] nc;
    @(negedge clk);
    tick_en = tick; cnt_wr_en = wr; cnt_wr_data = wd;
    cmp_wr_en = cwr; cmp_wr_data = cd; ovf_clr = clr;
    cmp_mode = g_mode; async_sel = g_async; adc_en = g_adc; ovf_irq_en = g_ien;
    period_end = (g_mode == 4'b1011) && (g_async == 1'b0) && (m_cnt == m_cmp);
    rolled = 1'b0;
    if (wr) nc = wd;
    else if (period_end) nc = 16'h0000;
    else if (tick) begin
      nc = m_cnt + 16'h0001;
      rolled = (m_cnt == 16'hFFFF);
    end else nc = m_cnt;
    m_cnt = nc;
    if (rolled) m_flg = 1'b1;
    else if (clr) m_flg = 1'b0;
    m_cv = period_end & g_adc;
    if (cwr) m_cmp = cd;
    exp_q.push_back({m_cnt, m_cmp, m_flg, m_flg & g_ien, m_cv});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [34:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {count, cmp_value, ovf_flag, ovf_irq, conv_start};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual cnt=%h cmp=%h flg=%b irq=%b cv=%b expected cnt=%h cmp=%h flg=%b irq=%b cv=%b",
                   t, a[34:19], a[18:3], a[2], a[1], a[0],
                   e[34:19], e[18:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if ({count, cmp_value, ovf_flag, ovf_irq, conv_start} !== 35'h0) begin
      n_bad++;
      $display("FAIL R1: actual=%h expected=0",
               {count, cmp_value, ovf_flag, ovf_irq, conv_start});
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: gapped then continuous ticks
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, "R2_gap");
      cyc(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, "R2_hold");
    end
    ticks(6, "R2_run");

    // R3: wrap with irq disabled then enabled
    cyc(1'b0, 1'b1, 16'hFFFD, 1'b0, 16'h0, 1'b0, "R6_load");
    ticks(4, "R3_wrap");
    g_ien = 1'b1;
    idle(2, "R3_irq");
    // R9: sticky and clear
    idle(3, "R9_sticky");
    cyc(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, "R9_clear");
    idle(1, "R9_cleared");
    // R9: wrap and clear in the same cycle
    cyc(1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0, 1'b0, "R6_load");
    cyc(1'b1, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, "R9_set_wins");
    cyc(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, "R9_clear2");

    // R10/R4/R7: period of 5 with converter on
    cyc(1'b0, 1'b1, 16'h0000, 1'b1, 16'h0005, 1'b0, "R10_cmp_wr");
    g_mode = 4'b1011; g_adc = 1'b1;
    ticks(14, "R4_R7_period");
    // R4: match clears even while tick is low
    cyc(1'b0, 1'b1, 16'h0005, 1'b0, 16'h0, 1'b0, "R6_load");
    idle(3, "R4_no_tick");
    // R7: converter off
    g_adc = 1'b0;
    ticks(12, "R7_adc_off");
    // R8: neighbouring mode code and async source
    g_adc = 1'b1; g_mode = 4'b1010;
    ticks(10, "R8_mode");
    g_mode = 4'b1011; g_async = 1'b1;
    cyc(1'b0, 1'b1, 16'h0000, 1'b0, 16'h0, 1'b0, "R6_load");
    ticks(10, "R8_async");
    g_async = 1'b0;
    // R6: write against a match
    cyc(1'b0, 1'b1, 16'h0005, 1'b0, 16'h0, 1'b0, "R6_load");
    cyc(1'b1, 1'b1, 16'h1234, 1'b0, 16'h0, 1'b0, "R6_write_wins");
    idle(2, "R6_after");
    // R10: compare write in a match cycle uses old value
    cyc(1'b0, 1'b1, 16'h0005, 1'b0, 16'h0, 1'b0, "R6_load");
    cyc(1'b1, 1'b0, 16'h0, 1'b1, 16'h0009, 1'b0, "R10_old_value");
    ticks(12, "R10_new_period");
    // R5: compare of all ones: clear at FFFF without flag
    cyc(1'b0, 1'b0, 16'h0, 1'b1, 16'hFFFF, 1'b1, "R10_cmp_wr");
    cyc(1'b0, 1'b1, 16'hFFFE, 1'b0, 16'h0, 1'b0, "R6_load");
    ticks(4, "R5_no_flag");
    g_mode = 4'h0;
    idle(2, "R5_end");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule